// File: doc/BRIEF.md
# CCD Split-Register Readout Timing Generator

This block produces the digital phase enables that read a full-frame CCD through a horizontal register split at its middle into a left and a right half. After a start pulse it waits out an integration time, then moves the image line by line into the horizontal register with the vertical phases and clocks each line out with the horizontal phases. The reset gate is pulsed once per pixel period and never stops. Analog levels and crossover voltages belong to the driver stage and are not handled here.

Two readout modes are selected at start. In single-line mode each line is loaded into register A and shifted out through the two A outputs. Transfer gate and register B stay idle. In paired mode a line is loaded into register A and passed through the transfer gate into register B. A second line is then loaded into register A, and both are shifted out together: the even line on the A outputs, the odd line on the B outputs. Every time in the sequence is a parameter counted in system clock cycles, and one pixel period is `PIX_DIV` system cycles.

The controller is one state machine with the states IDLE, INTEG, V1A, V2A, HOLD, XFER, SETTLE, V1B, V2B, SETUP and SHIFT. Its transitions are:
- IDLE→INTEG on start. The mode is latched at this point.
- INTEG→V1A→V2A as each timer expires.
- V2A→SETUP in single-line mode, or V2A→HOLD→XFER→SETTLE→V1B→V2B→SETUP in paired mode.
- SETUP→SHIFT when the setup timer expires.
- SHIFT→V1A after the last pixel of a line when more lines remain, or SHIFT→IDLE after the last line.

Top module: `ccd_readout_tg`

## Requirements
- R1: While idle after reset, `busy_o`, `v1_o`, `v2_o`, `xg_o` and all horizontal phases are low. `rg_o` keeps pulsing one cycle high every `PIX_DIV` cycles.
- R2: A start pulse in idle raises `busy_o` for exactly INT_CYC + FRAME_LINES·(2·V_WIDTH + H_SETUP + PIX_PER_LINE·PIX_DIV) cycles in single-line mode. In paired mode the count is INT_CYC + (FRAME_LINES/2)·(4·V_WIDTH + D_LOAD + D_XFER + D_SETTLE + H_SETUP + PIX_PER_LINE·PIX_DIV) cycles.
- R3: During the first INT_CYC busy cycles, `v1_o` and `v2_o` are both low. `v1_o` rises in the next cycle.
- R4: Each V1 and V2 pulse lasts exactly V_WIDTH cycles, and the two are never high together. `h1a_o` is high on the cycle before and the cycle after every V2 falling edge. FRAME_LINES V2 falling edges occur per frame.
- R5: The first pixel strobe after the V2 falling edge that loads a line comes exactly H_SETUP + PIX_DIV/2 cycles after that edge.
- R6: Each line gives PIX_PER_LINE strobes on `pix_a_o`, each in the cycle where `h1l_o` falls. `h2_o` is never high together with `h1a_o` or `h1l_o`, and `h1l_o` is high only when `h1a_o` is high.
- R7: In single-line mode, `xg_o`, `h1b_o` and `pix_b_o` stay low. `line_odd_o` carries bit 0 of the line index, counted from 0, so half of the lines are tagged odd.
- R8: In paired mode there are FRAME_LINES/2 transfer-gate pulses, each D_XFER cycles long. Each pulse rises exactly D_LOAD cycles after the V2 falling edge that loads the even line, and falls with `h1a_o` low. The next V1 rise comes exactly D_SETTLE cycles after the pulse falls.
- R9: In paired mode `pix_b_o` strobes in the same cycles as `pix_a_o`, and `line_odd_o` is 0: the A outputs carry even lines and the B outputs carry odd lines.
- R10: A start pulse while busy is ignored. A mode change on that pulse also has no effect on the running frame.
- R11: While busy, the gap between `rg_o` pulses never exceeds PIX_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame start pulse, accepted only when idle |
| mode_pair_i | input | 1 | 1 = paired four-output readout, 0 = single-line two-output readout |
| busy_o | output | 1 | High from start until the last pixel of the frame |
| v1_o | output | 1 | Vertical phase 1 enable |
| v2_o | output | 1 | Vertical phase 2 enable |
| h1a_o | output | 1 | Horizontal phase 1, register A |
| h1b_o | output | 1 | Horizontal phase 1, register B |
| h1l_o | output | 1 | Last horizontal gate before the output node |
| h2_o | output | 1 | Horizontal phase 2 |
| xg_o | output | 1 | Transfer gate between register A and register B |
| rg_o | output | 1 | Output node reset gate, one pulse per pixel period |
| pix_a_o | output | 1 | Pixel strobe for the A outputs |
| pix_b_o | output | 1 | Pixel strobe for the B outputs |
| line_odd_o | output | 1 | Parity tag of the line on the A outputs |

## Verification
The bench uses a small configuration: six pixels per line, four lines and a four-cycle pixel period. It runs a single-line frame, a paired frame, and a single-line frame hit by a second start with the opposite mode. The first two frames separate the two state paths by busy length, V2 edge count, transfer-gate activity and A/B strobe pairing. The edge-to-edge intervals measured on every line catch off-by-one errors in the load, hold, transfer, settle and setup counts. The disturbed frame must match the plain single-line frame exactly, which shows that the mid-frame start and the mode flip were both dropped.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_INTEG,
        S_V1A,
        S_V2A,
        S_HOLD,
        S_XFER,
        S_SETTLE,
        S_V1B,
        S_V2B,
        S_SETUP,
        S_SHIFT
    } tg_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ccd_tg_timer.sv
module ccd_tg_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R2: every timed state counts down one step per cycle
    p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ccd_tg_pixdiv.sv
module ccd_tg_pixdiv #(
    parameter int PIX_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic h1,
    output logic rg,
    output logic strobe,
    output logic last
);

    localparam int PW   = (PIX_DIV > 2) ? $clog2(PIX_DIV) : 1;
    localparam int HALF = PIX_DIV / 2;

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (restart || ph_q == PW'(PIX_DIV - 1))
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    assign h1     = (ph_q < PW'(HALF));
    assign rg     = (ph_q == '0);
    assign strobe = (ph_q == PW'(HALF));
    assign last   = (ph_q == PW'(PIX_DIV - 1));

    // R11: the reset gate is a single-cycle pulse
    p_rg_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rg && !restart) |=> !rg);

endmodule

// File: rtl/ccd_tg_count.sv
module ccd_tg_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (clr)
            value <= '0;
        else if (inc)
            value <= value + 1'b1;
    end

endmodule

// File: rtl/ccd_readout_tg.sv
module ccd_readout_tg
    import ccd_tg_pkg::*;
#(
    parameter int PIX_PER_LINE = 4152,
    parameter int FRAME_LINES  = 6220,
    parameter int PIX_DIV      = 4,
    parameter int INT_CYC      = 1000,
    parameter int V_WIDTH      = 20,
    parameter int D_LOAD       = 5,
    parameter int D_XFER       = 30,
    parameter int D_SETTLE     = 5,
    parameter int H_SETUP      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mode_pair_i,
    output logic busy_o,
    output logic v1_o,
    output logic v2_o,
    output logic h1a_o,
    output logic h1b_o,
    output logic h1l_o,
    output logic h2_o,
    output logic xg_o,
    output logic rg_o,
    output logic pix_a_o,
    output logic pix_b_o,
    output logic line_odd_o
);

    localparam int PAIRS = FRAME_LINES / 2;
    localparam int TMAX  = max_of(max_of(max_of(INT_CYC, V_WIDTH), max_of(D_LOAD, D_XFER)),
                                  max_of(D_SETTLE, H_SETUP));
    localparam int TW    = $clog2(TMAX + 1);
    localparam int PXW   = $clog2(PIX_PER_LINE + 1);
    localparam int LW    = $clog2(FRAME_LINES + 1);

    tg_state_e     state_q, state_n;
    logic          pair_q;
    logic          t_zero, t_load;
    logic [TW-1:0] t_val;
    logic          px_h1, px_rg, px_strobe, px_last, px_restart;
    logic [PXW-1:0] pix_cnt;
    logic [LW-1:0]  unit_cnt;
    logic          line_end, frame_end;
    logic [LW-1:0] units_m1;

    assign units_m1  = pair_q ? LW'(PAIRS - 1) : LW'(FRAME_LINES - 1);
    assign line_end  = (state_q == S_SHIFT) && px_last && (pix_cnt == PXW'(PIX_PER_LINE - 1));
    assign frame_end = line_end && (unit_cnt == units_m1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pair_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_q == S_IDLE && start_i)
                pair_q <= mode_pair_i;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_n = S_INTEG;
            S_INTEG:  if (t_zero)  state_n = S_V1A;
            S_V1A:    if (t_zero)  state_n = S_V2A;
            S_V2A:    if (t_zero)  state_n = pair_q ? S_HOLD : S_SETUP;
            S_HOLD:   if (t_zero)  state_n = S_XFER;
            S_XFER:   if (t_zero)  state_n = S_SETTLE;
            S_SETTLE: if (t_zero)  state_n = S_V1B;
            S_V1B:    if (t_zero)  state_n = S_V2B;
            S_V2B:    if (t_zero)  state_n = S_SETUP;
            S_SETUP:  if (t_zero)  state_n = S_SHIFT;
            S_SHIFT:  if (line_end) state_n = frame_end ? S_IDLE : S_V1A;
            default:  state_n = S_IDLE;
        endcase
    end

    // state durations, loaded on every state change
    always_comb begin
        t_load = (state_n != state_q);
        unique case (state_n)
            S_INTEG:        t_val = TW'(INT_CYC - 1);
            S_V1A, S_V2A,
            S_V1B, S_V2B:   t_val = TW'(V_WIDTH - 1);
            S_HOLD:         t_val = TW'(D_LOAD - 1);
            S_XFER:         t_val = TW'(D_XFER - 1);
            S_SETTLE:       t_val = TW'(D_SETTLE - 1);
            S_SETUP:        t_val = TW'(H_SETUP - 1);
            default:        t_val = '0;
        endcase
    end

    assign px_restart = (state_q == S_SETUP) && t_zero;

    ccd_tg_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    ccd_tg_pixdiv #(.PIX_DIV(PIX_DIV)) u_pixdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (px_restart),
        .h1      (px_h1),
        .rg      (px_rg),
        .strobe  (px_strobe),
        .last    (px_last)
    );

    ccd_tg_count #(.W(PXW)) u_pix_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_q != S_SHIFT) || line_end),
        .inc   ((state_q == S_SHIFT) && px_last),
        .value (pix_cnt)
    );

    ccd_tg_count #(.W(LW)) u_unit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == S_IDLE),
        .inc   (line_end),
        .value (unit_cnt)
    );

    // outputs
    always_comb begin
        busy_o     = 1'b1;
        v1_o       = 1'b0;
        v2_o       = 1'b0;
        h1a_o      = 1'b1;
        h1b_o      = pair_q;
        h1l_o      = 1'b0;
        h2_o       = 1'b0;
        xg_o       = 1'b0;
        pix_a_o    = 1'b0;
        pix_b_o    = 1'b0;
        line_odd_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o = 1'b0;
                h1a_o  = 1'b0;
                h1b_o  = 1'b0;
            end
            S_V1A, S_V1B:   v1_o = 1'b1;
            S_V2A, S_V2B:   v2_o = 1'b1;
            S_XFER: begin
                h1a_o = 1'b0;
                xg_o  = 1'b1;
            end
            S_SHIFT: begin
                h1a_o      = px_h1;
                h1b_o      = pair_q & px_h1;
                h1l_o      = px_h1;
                h2_o       = ~px_h1;
                pix_a_o    = px_strobe;
                pix_b_o    = px_strobe & pair_q;
                line_odd_o = ~pair_q & unit_cnt[0];
            end
            default: ;
        endcase
    end

    assign rg_o = px_rg;

    // R4: vertical phases never overlap
    p_vert_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(v1_o && v2_o));
    // R4: a line is loaded only with H1A held high
    p_load_h1a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v2_o) |-> (h1a_o && $past(h1a_o)));
    // R3: integration starts with both vertical phases low
    p_integ_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!v1_o && !v2_o));
    // R7: single-line mode keeps the B path idle
    p_single_idle_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_q |-> (!xg_o && !h1b_o && !pix_b_o));
    // R6: pixel count stays within the line
    p_pix_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_cnt < PXW'(PIX_PER_LINE));
    // R6: strobe only where the last gate falls
    p_strobe_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_a_o |-> (!h1l_o && $past(h1l_o)));
    // R10: a start while busy leaves the latched mode alone
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start_i) |=> $stable(pair_q));

endmodule

// File: tb/ccd_readout_tg_tb.sv
module ccd_readout_tg_tb;

    localparam int PIX = 6;
    localparam int LNS = 4;
    localparam int DIV = 4;
    localparam int INT = 7;
    localparam int VW  = 3;
    localparam int D1  = 2;
    localparam int D2  = 4;
    localparam int D3  = 2;
    localparam int HS  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mode_pair_i = 1'b0;
    logic busy_o, v1_o, v2_o, h1a_o, h1b_o, h1l_o, h2_o, xg_o, rg_o;
    logic pix_a_o, pix_b_o, line_odd_o;

    always #10 clk = ~clk;

    ccd_readout_tg #(
        .PIX_PER_LINE(PIX), .FRAME_LINES(LNS), .PIX_DIV(DIV), .INT_CYC(INT),
        .V_WIDTH(VW), .D_LOAD(D1), .D_XFER(D2), .D_SETTLE(D3), .H_SETUP(HS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_pair_i(mode_pair_i),
        .busy_o(busy_o), .v1_o(v1_o), .v2_o(v2_o), .h1a_o(h1a_o), .h1b_o(h1b_o),
        .h1l_o(h1l_o), .h2_o(h2_o), .xg_o(xg_o), .rg_o(rg_o),
        .pix_a_o(pix_a_o), .pix_b_o(pix_b_o), .line_odd_o(line_odd_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int cyc = 0, bidx = 0;
    int n_busy, n_pa, n_pb, n_odd, n_v2f, n_xgr, n_xg_hi, n_h1b, n_rg;
    int v_integ, v_vw, v_load, v_setup, v_d1, v_d2, v_d3, v_edge, v_comp, v_rg, v_ab;
    int v1run = 0, v2run = 0, t_v2f = 0, t_xgr = 0, t_xgf = 0, rg_gap = 0;
    bit wait_px = 0, chk_d3 = 0;
    logic p_v1 = 0, p_v2 = 0, p_h1a = 0, p_h1l = 0, p_xg = 0;

    task automatic clear_stats();
        n_busy = 0; n_pa = 0; n_pb = 0; n_odd = 0; n_v2f = 0; n_xgr = 0;
        n_xg_hi = 0; n_h1b = 0; n_rg = 0; bidx = 0;
        v_integ = 0; v_vw = 0; v_load = 0; v_setup = 0; v_d1 = 0; v_d2 = 0;
        v_d3 = 0; v_edge = 0; v_comp = 0; v_rg = 0; v_ab = 0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (busy_o) begin
            n_busy++;
            if (bidx < INT && (v1_o || v2_o)) v_integ++;
            if (bidx == INT && !v1_o) v_integ++;
            bidx++;
            if (rg_o && rg_gap > DIV) v_rg++;
        end
        if (rg_o) begin n_rg++; rg_gap = 1; end else rg_gap++;
        if (v1_o) v1run++; else if (p_v1) begin if (v1run != VW) v_vw++; v1run = 0; end
        if (v2_o) v2run++; else if (p_v2) begin if (v2run != VW) v_vw++; v2run = 0; end
        if (v1_o && v2_o) v_vw++;
        if (p_v2 && !v2_o) begin
            n_v2f++; t_v2f = cyc; wait_px = 1;
            if (!h1a_o || !p_h1a) v_load++;
        end
        if (pix_a_o) begin
            n_pa++;
            if (line_odd_o) n_odd++;
            if (wait_px) begin
                if (cyc - t_v2f != HS + DIV/2) v_setup++;
                wait_px = 0;
            end
            if (!(p_h1l && !h1l_o)) v_edge++;
        end
        if (pix_b_o) n_pb++;
        if (pix_a_o != pix_b_o) v_ab++;
        if (h2_o && (h1a_o || h1l_o)) v_comp++;
        if (h1l_o && !h1a_o) v_comp++;
        if (h1b_o) n_h1b++;
        if (xg_o) n_xg_hi++;
        if (xg_o && !p_xg) begin
            n_xgr++; t_xgr = cyc;
            if (cyc - t_v2f != D1) v_d1++;
            if (h1a_o) v_d1++;
        end
        if (!xg_o && p_xg) begin
            t_xgf = cyc; chk_d3 = 1;
            if (cyc - t_xgr != D2) v_d2++;
        end
        if (v1_o && !p_v1 && chk_d3) begin
            if (cyc - t_xgf != D3) v_d3++;
            chk_d3 = 0;
        end
        p_v1 = v1_o; p_v2 = v2_o; p_h1a = h1a_o; p_h1l = h1l_o; p_xg = xg_o;
    end

    task automatic run_frame(input bit pair, input bit disturb);
        @(negedge clk);
        clear_stats();
        mode_pair_i = pair;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mode_pair_i = 1'b0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            mode_pair_i = !pair;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            mode_pair_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    localparam int DS_BUSY  = INT + LNS * (2*VW + HS + PIX*DIV);
    localparam int DPS_BUSY = INT + (LNS/2) * (4*VW + D1 + D2 + D3 + HS + PIX*DIV);

    task automatic check_common();
        chk("R3", "integration phases", v_integ, 0);
        chk("R4", "vertical widths", v_vw, 0);
        chk("R4", "load with h1a", v_load, 0);
        chk("R4", "v2 falls", n_v2f, LNS);
        chk("R5", "setup delay", v_setup, 0);
        chk("R6", "strobe edge", v_edge, 0);
        chk("R6", "phase complement", v_comp, 0);
        chk("R11", "rg gap", v_rg, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy idle", busy_o, 0);
        chk("R1", "vertical idle", v1_o | v2_o, 0);
        chk("R1", "horizontal idle", h1a_o | h1b_o | h1l_o | h2_o | xg_o, 0);
        clear_stats();
        repeat (40) @(negedge clk);
        chk("R1", "rg pulses idle", n_rg, 40 / DIV);

        // single-line frame
        run_frame(1'b0, 1'b0);
        chk("R2", "single busy", n_busy, DS_BUSY);
        chk("R6", "single strobes", n_pa, LNS * PIX);
        chk("R7", "single b strobes", n_pb, 0);
        chk("R7", "single xg", n_xgr + n_xg_hi, 0);
        chk("R7", "single h1b", n_h1b, 0);
        chk("R7", "odd tags", n_odd, (LNS/2) * PIX);
        check_common();

        // paired frame
        run_frame(1'b1, 1'b0);
        chk("R2", "paired busy", n_busy, DPS_BUSY);
        chk("R9", "paired a strobes", n_pa, (LNS/2) * PIX);
        chk("R9", "paired b strobes", n_pb, (LNS/2) * PIX);
        chk("R9", "a/b alignment", v_ab, 0);
        chk("R9", "odd tags", n_odd, 0);
        chk("R8", "xg pulses", n_xgr, LNS/2);
        chk("R8", "xg high cycles", n_xg_hi, (LNS/2) * D2);
        chk("R8", "v2 to xg", v_d1, 0);
        chk("R8", "xg width", v_d2, 0);
        chk("R8", "xg to v1", v_d3, 0);
        check_common();

        // single-line frame with a start and mode flip while busy
        run_frame(1'b0, 1'b1);
        chk("R10", "busy unchanged", n_busy, DS_BUSY);
        chk("R10", "strobes unchanged", n_pa, LNS * PIX);
        chk("R10", "no xg after flip", n_xgr, 0);
        chk("R10", "no b strobes", n_pb, 0);
        check_common();

        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule